// File: doc/BRIEF.md
# Halfword and Doubleword Transfer Address Unit

This block generates addresses and sequences memory accesses for the load/store class that moves halfwords, signed bytes and register pairs. A request supplies the base register value and its index, an offset (an 8-bit immediate split into two 4-bit fields, or a full register value), the indexing controls (pre/post, add/subtract, writeback) and three selectors that choose the transfer kind. The block forms the access address and the updated base. It then drives a single memory request, or two word requests for a register pair. It returns each loaded value, already extended, with its destination index, and it reports the base writeback when the transfer completes.

Some requests are rejected before any memory access. A register-pair transfer that names an odd first register is marked undefined. An access address below a programmable guard limit raises an access fault. In both cases there is no memory traffic and no writeback. A writeback whose base register is also a transfer destination still goes ahead, but it is reported on a separate flag so that the surrounding pipeline can decide the ordering.

Top module: `hdx_addr_unit`

## Requirements
- R1: With `req_imm`=1 the offset is `{imm_hi, imm_lo}` zero-extended (imm_hi forms bits 7:4). With `req_imm`=0 the offset is `reg_off`.
- R2: Post-indexed (`req_pre`=0): the access uses the unmodified base, and writeback of base±offset always takes place, whatever `req_wbit` is.
- R3: Pre-indexed (`req_pre`=1): the access uses base±offset, and writeback takes place only when `req_wbit`=1.
- R4: `req_up`=1 adds the offset and `req_up`=0 subtracts it. `wb_val` carries the updated base, and `wb_idx` equals `base_idx`.
- R5: Kind is chosen by {req_sgn,req_load,req_half}. 01x is an unsigned halfword load, and its result is zero-extended from bits 15:0. 00x is a halfword store that drives `mem_wdata` = {16'h0, store_lo[15:0]}. Both use `mem_size`=1. Sizes are encoded 0 byte, 1 halfword, 2 word.
- R6: 111 is a signed halfword load (`mem_size`=1) and 110 is a signed byte load (`mem_size`=0). Each is sign-extended from bit 15 or bit 7 of `mem_rdata`. Memory returns the addressed item in the low bits of `mem_rdata`.
- R7: 100 loads a register pair and 101 stores one. There are two word beats, at A and then A+4, for registers `dst_idx` and `dst_idx`|1. A store drives `store_lo` and then `store_hi`.
- R8: A pair transfer with odd `dst_idx` completes with `undef`=1, with no memory request, no register write and no writeback.
- R9: An access address below `FAULT_LIMIT` completes with `fault`=1, with no memory request, no register write and no writeback.
- R10: Each beat holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until it is accepted by `mem_ready`. Each beat is issued once.
- R11: `unpred` pulses with `done` when writeback is enabled and `base_idx` equals a destination register of the transfer (for a pair, either of the two registers).
- R12: After reset, `busy`, `mem_req`, `done`, `rd_we` and `wb_en` are 0. Each request ends with exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer (taken when not busy) |
| req_sgn | input | 1 | Kind selector, signed/pair group |
| req_load | input | 1 | Kind selector, load direction |
| req_half | input | 1 | Kind selector, halfword / pair store |
| req_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| req_up | input | 1 | 1 add offset, 0 subtract |
| req_wbit | input | 1 | Writeback request for pre-indexed forms |
| req_imm | input | 1 | 1 immediate offset, 0 register offset |
| imm_hi | input | NIB_W | Upper immediate nibble |
| imm_lo | input | NIB_W | Lower immediate nibble |
| reg_off | input | DW | Register offset value |
| base_val | input | DW | Base register value |
| base_idx | input | RIDX_W | Base register index |
| dst_idx | input | RIDX_W | Destination / first transfer register |
| store_lo | input | DW | Store data for dst_idx |
| store_hi | input | DW | Store data for dst_idx|1 |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr | output | DW | Beat address |
| mem_wdata | output | DW | Beat write data |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | DW | Read data, item in low bits |
| rd_we | output | 1 | Register write strobe |
| rd_idx | output | RIDX_W | Register written |
| rd_data | output | DW | Extended load value |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | RIDX_W | Base register index for writeback |
| wb_val | output | DW | Updated base value |
| done | output | 1 | Transfer complete pulse |
| fault | output | 1 | Access fault, with done |
| undef | output | 1 | Odd pair register, with done |
| unpred | output | 1 | Base/destination overlap, with done |

## Verification
The hardest case to reach is the second word of a pair transfer while memory is stalling. Here the address must advance by exactly four, and the beat must not repeat while `mem_ready` is low. The bench answers every request through a memory responder that inserts a per-vector number of wait cycles. Pair loads and stores then meet zero, one and three stall cycles, with each beat recorded once at the cycle it is accepted. The reject paths are driven with the indexing controls that would otherwise force a writeback, such as a post-indexed faulting access, so that any writeback leak appears at the ports.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [2:0] {
    K_LDH_U = 3'd0,
    K_STH   = 3'd1,
    K_LDSH  = 3'd2,
    K_LDSB  = 3'd3,
    K_LDD   = 3'd4,
    K_STD   = 3'd5
  } xfer_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BEAT0 = 2'd1,
    S_BEAT1 = 2'd2
  } seq_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  function automatic xfer_e decode_xfer(input logic sgn, input logic ld, input logic half);
    xfer_e k;
    if (!sgn)      k = ld ? K_LDH_U : K_STH;
    else if (ld)   k = half ? K_LDSH : K_LDSB;
    else           k = half ? K_STD : K_LDD;
    return k;
  endfunction

  function automatic logic is_pair(input xfer_e k);
    return (k == K_LDD) || (k == K_STD);
  endfunction

  function automatic logic is_load(input xfer_e k);
    return (k == K_LDH_U) || (k == K_LDSH) || (k == K_LDSB) || (k == K_LDD);
  endfunction

endpackage

// File: rtl/hdx_ea_gen.sv
module hdx_ea_gen #(
  parameter int DW    = 32,
  parameter int NIB_W = 4
) (
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    reg_off,
  input  logic [NIB_W-1:0] imm_hi,
  input  logic [NIB_W-1:0] imm_lo,
  input  logic             imm_sel,
  input  logic             pre,
  input  logic             up,
  input  logic             wbit,
  output logic [DW-1:0]    ea,
  output logic [DW-1:0]    new_base,
  output logic             do_wb
);
  localparam int IMM_W = 2 * NIB_W;

  logic [IMM_W-1:0] imm_val;
  logic [DW-1:0]    offset;
  logic [DW-1:0]    moved;

  always_comb begin
    imm_val  = {imm_hi, imm_lo};
    offset   = imm_sel ? DW'(imm_val) : reg_off;
    moved    = up ? (base + offset) : (base - offset);
    ea       = pre ? moved : base;
    new_base = moved;
    do_wb    = !pre || wbit;
  end
endmodule

// File: rtl/hdx_ld_ext.sv
module hdx_ld_ext #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]  raw,
  input  hdx_pkg::xfer_e kind,
  output logic [DW-1:0]  value
);
  import hdx_pkg::*;

  always_comb begin
    case (kind)
      K_LDH_U: value = {{(DW-16){1'b0}}, raw[15:0]};
      K_LDSH:  value = {{(DW-16){raw[15]}}, raw[15:0]};
      K_LDSB:  value = {{(DW-8){raw[7]}}, raw[7:0]};
      default: value = raw;
    endcase
  end
endmodule

// File: rtl/hdx_addr_unit.sv
module hdx_addr_unit #(
  parameter int DW          = 32,
  parameter int NIB_W       = 4,
  parameter int RIDX_W      = 4,
  parameter int FAULT_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_sgn,
  input  logic              req_load,
  input  logic              req_half,
  input  logic              req_pre,
  input  logic              req_up,
  input  logic              req_wbit,
  input  logic              req_imm,
  input  logic [NIB_W-1:0]  imm_hi,
  input  logic [NIB_W-1:0]  imm_lo,
  input  logic [DW-1:0]     reg_off,
  input  logic [DW-1:0]     base_val,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [DW-1:0]     store_lo,
  input  logic [DW-1:0]     store_hi,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rd_we,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [DW-1:0]     wb_val,
  output logic              done,
  output logic              fault,
  output logic              undef,
  output logic              unpred
);
  import hdx_pkg::*;

  localparam logic [DW-1:0] LIMIT   = DW'(FAULT_LIMIT);
  localparam logic [DW-1:0] WORD_SZ = DW'(4);

  // request-side decode
  logic [DW-1:0] ea, new_base;
  logic          do_wb;
  xfer_e         kind_in;
  logic          pair_in;
  logic [RIDX_W-1:0] odd_in;
  logic          overlap_in;

  hdx_ea_gen #(.DW(DW), .NIB_W(NIB_W)) u_ea (
    .base(base_val), .reg_off(reg_off), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .imm_sel(req_imm), .pre(req_pre), .up(req_up), .wbit(req_wbit),
    .ea(ea), .new_base(new_base), .do_wb(do_wb)
  );

  always_comb begin
    kind_in    = decode_xfer(req_sgn, req_load, req_half);
    pair_in    = is_pair(kind_in);
    odd_in     = {dst_idx[RIDX_W-1:1], 1'b1};
    overlap_in = do_wb && ((base_idx == dst_idx) || (pair_in && (base_idx == odd_in)));
  end

  // held transfer state
  seq_e              state;
  xfer_e             op_q;
  logic [DW-1:0]     addr_q;
  logic [DW-1:0]     lo_q, hi_q;
  logic [RIDX_W-1:0] dst_q;
  logic              wb_q, unp_q;
  logic [DW-1:0]     ext_val;

  hdx_ld_ext #(.DW(DW)) u_ext (.raw(mem_rdata), .kind(op_q), .value(ext_val));

  // beat outputs come straight from registered state
  always_comb begin
    busy     = (state != S_IDLE);
    mem_req  = busy;
    mem_addr = addr_q;
    mem_we   = (op_q == K_STH) || (op_q == K_STD);
    case (op_q)
      K_LDSB:                  mem_size = SZ_BYTE;
      K_LDH_U, K_STH, K_LDSH:  mem_size = SZ_HALF;
      default:                 mem_size = SZ_WORD;
    endcase
    if (state == S_BEAT1)      mem_wdata = hi_q;
    else if (op_q == K_STH)    mem_wdata = {{(DW-16){1'b0}}, lo_q[15:0]};
    else                       mem_wdata = lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op_q   <= K_LDH_U;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      dst_q  <= '0;
      wb_q   <= 1'b0;
      unp_q  <= 1'b0;
      rd_we  <= 1'b0;
      rd_idx <= '0;
      rd_data<= '0;
      wb_en  <= 1'b0;
      wb_idx <= '0;
      wb_val <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
      undef  <= 1'b0;
      unpred <= 1'b0;
    end else begin
      rd_we  <= 1'b0;
      wb_en  <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
      undef  <= 1'b0;
      unpred <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= kind_in;
            addr_q <= ea;
            lo_q   <= store_lo;
            hi_q   <= store_hi;
            dst_q  <= dst_idx;
            wb_q   <= do_wb;
            unp_q  <= overlap_in;
            wb_idx <= base_idx;
            wb_val <= new_base;
            if (pair_in && dst_idx[0]) begin
              done  <= 1'b1;
              undef <= 1'b1;
            end else if (ea < LIMIT) begin
              done  <= 1'b1;
              fault <= 1'b1;
            end else begin
              state <= S_BEAT0;
            end
          end
        end
        S_BEAT0: begin
          if (mem_ready) begin
            if (is_load(op_q)) begin
              rd_we   <= 1'b1;
              rd_idx  <= dst_q;
              rd_data <= ext_val;
            end
            if (is_pair(op_q)) begin
              state  <= S_BEAT1;
              addr_q <= addr_q + WORD_SZ;
            end else begin
              state  <= S_IDLE;
              done   <= 1'b1;
              wb_en  <= wb_q;
              unpred <= unp_q;
            end
          end
        end
        S_BEAT1: begin
          if (mem_ready) begin
            if (is_load(op_q)) begin
              rd_we   <= 1'b1;
              rd_idx  <= {dst_q[RIDX_W-1:1], 1'b1};
              rd_data <= ext_val;
            end
            state  <= S_IDLE;
            done   <= 1'b1;
            wb_en  <= wb_q;
            unpred <= unp_q;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_addr_unit_chk.sv
module hdx_addr_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          rd_we,
  input logic          wb_en,
  input logic          done,
  input logic          fault,
  input logic          undef
);
  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_pair_step_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(mem_req && mem_ready) && mem_req) |-> (mem_addr == $past(mem_addr) + DW'(4)));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !wb_en && !rd_we && !mem_req));

  assert_undef_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    undef |-> (done && !wb_en && !rd_we && !mem_req && !fault));

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> (!mem_req && !done && !wb_en && !rd_we));
endmodule

bind hdx_addr_unit hdx_addr_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_we(rd_we), .wb_en(wb_en),
  .done(done), .fault(fault), .undef(undef)
);

// File: tb/hdx_addr_unit_bench.sv
`timescale 1ns/1ps
module hdx_addr_unit_bench;
  typedef struct packed {
    logic [2:0]  kind;   // {sgn, load, half}
    logic        pre, up, w, imm;
    logic [7:0]  imm8;
    logic [31:0] roff, base;
    logic [3:0]  dst, bidx;
    logic [31:0] slo, shi;
    logic [1:0]  wt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{3'b011, 1'b1, 1'b1, 1'b0, 1'b1, 8'h14, 32'h0,  32'h2000, 4'd2,  4'd5, 32'h0,         32'h0,         2'd0},
    '{3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h10, 32'h3000, 4'd3,  4'd6, 32'hDEAD_BEEF, 32'h0,         2'd2},
    '{3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 32'h0,  32'h4100, 4'd7,  4'd1, 32'h0,         32'h0,         2'd1},
    '{3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 32'h3,  32'h5000, 4'd0,  4'd4, 32'h0,         32'h0,         2'd0},
    '{3'b100, 1'b1, 1'b1, 1'b1, 1'b1, 8'h08, 32'h0,  32'h6000, 4'd4,  4'd9, 32'h0,         32'h0,         2'd1},
    '{3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h20, 32'h7000, 4'd10, 4'd2, 32'h1111_2222, 32'h3333_4444, 2'd3},
    '{3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 32'h0,  32'h8080, 4'd1,  4'd2, 32'h0,         32'h0,         2'd0},
    '{3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 8'h22, 32'h0,  32'h9000, 4'd8,  4'd3, 32'h0,         32'h0,         2'd2}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_sgn = 0, req_load = 0, req_half = 0, req_pre = 0, req_up = 0, req_wbit = 0, req_imm = 0;
  logic [3:0] imm_hi = 0, imm_lo = 0, base_idx = 0, dst_idx = 0;
  logic [31:0] reg_off = 0, base_val = 0, store_lo = 0, store_hi = 0;
  logic busy, mem_req, mem_we, rd_we, wb_en, done, fault, undef, unpred;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata, rd_data, wb_val;
  logic [3:0] rd_idx, wb_idx;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h8000};
  endfunction
  assign mem_rdata = pat(mem_addr);

  hdx_addr_unit u_hdx_addr_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sgn(req_sgn), .req_load(req_load),
    .req_half(req_half), .req_pre(req_pre), .req_up(req_up), .req_wbit(req_wbit),
    .req_imm(req_imm), .imm_hi(imm_hi), .imm_lo(imm_lo), .reg_off(reg_off),
    .base_val(base_val), .base_idx(base_idx), .dst_idx(dst_idx), .store_lo(store_lo),
    .store_hi(store_hi), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_data(rd_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .done(done),
    .fault(fault), .undef(undef), .unpred(unpred)
  );

  // memory responder and monitor, all at the falling edge
  int cur_wait = 0, wcnt = 0;
  int acc_n, rdw_n, done_n;
  logic [31:0] acc_addr [2], acc_wd [2], rdw_data [2];
  logic acc_we [2];
  logic [1:0] acc_size [2];
  logic [3:0] rdw_idx [2];
  logic s_fault, s_undef, s_unpred, s_wb;
  logic [3:0] s_wbidx;
  logic [31:0] s_wbval;

  task automatic clear_mon();
    acc_n = 0; rdw_n = 0; done_n = 0;
    s_fault = 0; s_undef = 0; s_unpred = 0; s_wb = 0; s_wbidx = 0; s_wbval = 0;
  endtask

  always @(negedge clk) begin
    if (rd_we) begin
      if (rdw_n < 2) begin rdw_idx[rdw_n] = rd_idx; rdw_data[rdw_n] = rd_data; end
      rdw_n++;
    end
    if (done) begin
      done_n++; s_fault = fault; s_undef = undef; s_unpred = unpred;
      s_wb = wb_en; s_wbidx = wb_idx; s_wbval = wb_val;
    end
    if (mem_ready) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= cur_wait) begin
        mem_ready = 1'b1;
        if (acc_n < 2) begin
          acc_addr[acc_n] = mem_addr; acc_we[acc_n] = mem_we;
          acc_size[acc_n] = mem_size; acc_wd[acc_n] = mem_wdata;
        end
        acc_n++;
      end else wcnt++;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] off, moved, addr;
    logic wbe, pair, ld, xund, xflt, xunp;
    logic [31:0] xd0, xd1;
    logic [1:0] xsz;
    logic xwe;
    off   = v.imm ? {24'h0, v.imm8} : v.roff;
    moved = v.up ? v.base + off : v.base - off;
    addr  = v.pre ? moved : v.base;
    wbe   = !v.pre || v.w;
    pair  = (v.kind[2:1] == 2'b10);
    ld    = (v.kind[2:1] == 2'b01) || (v.kind == 3'b111) || (v.kind == 3'b110) || (v.kind == 3'b100);
    xwe   = (v.kind[2:1] == 2'b00) || (v.kind == 3'b101);
    xund  = pair && v.dst[0];
    xflt  = !xund && (addr < 32'd256);
    xunp  = !xund && !xflt && wbe && ((v.bidx == v.dst) || (pair && v.bidx == {v.dst[3:1], 1'b1}));
    xsz   = (v.kind == 3'b110) ? 2'd0 : (pair ? 2'd2 : 2'd1);
    case (v.kind)
      3'b111:  xd0 = {{16{pat(addr)[15]}}, pat(addr)[15:0]};
      3'b110:  xd0 = {{24{pat(addr)[7]}}, pat(addr)[7:0]};
      3'b100:  xd0 = pat(addr);
      default: xd0 = {16'h0, pat(addr)[15:0]};
    endcase
    xd1 = pat(addr + 32'd4);

    clear_mon();
    cur_wait = int'(v.wt);
    @(negedge clk);
    req_sgn = v.kind[2]; req_load = v.kind[1]; req_half = v.kind[0];
    req_pre = v.pre; req_up = v.up; req_wbit = v.w; req_imm = v.imm;
    imm_hi = v.imm8[7:4]; imm_lo = v.imm8[3:0]; reg_off = v.roff; base_val = v.base;
    base_idx = v.bidx; dst_idx = v.dst; store_lo = v.slo; store_hi = v.shi;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && done_n == 0; i++) @(negedge clk);
    @(negedge clk);

    chk(done_n == 1, "R12 one done", done_n, 1);
    chk(s_undef == xund, "R8 undef", s_undef, xund);
    chk(s_fault == xflt, "R9 fault", s_fault, xflt);
    chk(s_unpred == xunp, "R11 unpred", s_unpred, xunp);
    if (xund || xflt) begin
      chk(acc_n == 0, "R8/R9 no access", acc_n, 0);
      chk(rdw_n == 0, "R8/R9 no reg write", rdw_n, 0);
      chk(s_wb == 0, "R8/R9 no writeback", s_wb, 0);
    end else begin
      chk(acc_n == (pair ? 2 : 1), "R10 beat count", acc_n, pair ? 2 : 1);
      chk(acc_addr[0] == addr, v.pre ? "R1 R3 address" : "R1 R2 address", acc_addr[0], addr);
      chk(acc_size[0] == xsz, "R5 R6 size", acc_size[0], xsz);
      chk(acc_we[0] == xwe, "R5 R7 direction", acc_we[0], xwe);
      chk(s_wb == wbe, v.pre ? "R3 writeback" : "R2 writeback", s_wb, wbe);
      if (wbe) begin
        chk(s_wbval == moved, "R4 updated base", s_wbval, moved);
        chk(s_wbidx == v.bidx, "R4 base index", s_wbidx, v.bidx);
      end
      if (xwe) begin
        if (pair) begin
          chk(acc_wd[0] == v.slo, "R7 store first", acc_wd[0], v.slo);
          chk(acc_wd[1] == v.shi, "R7 store second", acc_wd[1], v.shi);
        end else
          chk(acc_wd[0] == {16'h0, v.slo[15:0]}, "R5 half store data", acc_wd[0], {16'h0, v.slo[15:0]});
      end else begin
        chk(rdw_n == (pair ? 2 : 1), "R7 reg write count", rdw_n, pair ? 2 : 1);
        chk(rdw_data[0] == xd0, "R5 R6 load value", rdw_data[0], xd0);
        chk(rdw_idx[0] == v.dst, "R7 first index", rdw_idx[0], v.dst);
        if (pair) begin
          chk(rdw_data[1] == xd1, "R7 second value", rdw_data[1], xd1);
          chk(rdw_idx[1] == {v.dst[3:1], 1'b1}, "R7 odd index", rdw_idx[1], {v.dst[3:1], 1'b1});
        end
      end
      if (pair) chk(acc_addr[1] == addr + 32'd4, "R7 second address", acc_addr[1], addr + 32'd4);
    end
  endtask

  logic wd_hit = 1'b0;
  initial begin
    #(5.0 * 150000);
    wd_hit = 1'b1;
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!busy && !mem_req && !done && !rd_we && !wb_en, "R12 reset idle",
        {busy, mem_req, done, rd_we, wb_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req, "R12 idle after release", {busy, mem_req}, 0);

    for (int k = 0; k < NV; k++) run_vec(TBL[k]);

    // R8 odd pair register, pre-indexed with writeback requested
    run_vec('{3'b100, 1'b1, 1'b1, 1'b1, 1'b1, 8'h10, 32'h0, 32'hA000, 4'd3, 4'd6, 32'h0, 32'h0, 2'd0});
    // R8 odd pair store, post-indexed
    run_vec('{3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h8, 32'hA100, 4'd5, 4'd1, 32'h5, 32'h6, 2'd0});
    // R9 pre-indexed address lands below the guard
    run_vec('{3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 8'h10, 32'h0, 32'h0080, 4'd2, 4'd3, 32'h0, 32'h0, 2'd0});
    // R9 post-indexed fault: forced writeback must still be suppressed
    run_vec('{3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 32'h400, 32'h0040, 4'd2, 4'd3, 32'h0, 32'h0, 2'd0});
    // R9 boundary: exactly at the guard is legal
    run_vec('{3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h100, 32'h0200, 4'd2, 4'd3, 32'h0, 32'h0, 2'd0});
    // R11 base equals destination with writeback
    run_vec('{3'b011, 1'b1, 1'b1, 1'b1, 1'b1, 8'h02, 32'h0, 32'hB000, 4'd6, 4'd6, 32'h0, 32'h0, 2'd1});
    // R11 base equals odd register of a pair, post-indexed
    run_vec('{3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 32'h0, 32'hB100, 4'd4, 4'd5, 32'h7, 32'h8, 2'd0});
    // R11 overlap without writeback is not flagged; R3 no writeback
    run_vec('{3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 8'h06, 32'h0, 32'hB200, 4'd9, 4'd9, 32'h0, 32'h0, 2'd0});

    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule